// File: doc/BRIEF.md
# SEC-DED Memory Word Protector

This unit guards a 16-bit memory word with 6 check bits. Six check bits can correct any single-bit error and detect any double-bit error. On a write the unit forms the check word from the data on the bus, and the memory stores data and check together as a 22-bit word. On a read the unit captures the 22-bit word and forms a 6-bit syndrome from it. From the syndrome it raises a single-error or a double-error flag. It then drives corrected data and the syndrome back onto the buses.

Two mode inputs select the operation:

| mode_hi | mode_lo | Operation |
|---------|---------|-----------|
| 0 | 0 | Generate a check word |
| 0 | 1 | Accept input (outputs released) |
| 1 | 1 | Capture the word and update the flags |
| 1 | 0 | Drive corrected data and the syndrome |

The word is captured on the clock edge where mode_hi is first seen high. The bus drivers are modelled as output-enable signals rather than tri-state pads.

The code is chosen so that a stored word of all zeros or all ones is always reported as an error. An error in a check bit is flagged, but the data passes through unchanged.

Top module: `edac_sec_ded`

## Requirements
- R1: With mode 00, chk_out equals the check word of data_in. Check bit j is the XOR of the data bits whose column has bit j set. The columns for data bits 0 to 15 are 13, 14, 19, 21, 22, 25, 26, 28, 35, 37, 38, 41, 42, 44, 49 and 50. Check bits 0 and 1 are then complemented.
- R2: data_oe is high only in mode 10. chk_oe is high in modes 00 and 10.
- R3: data_in and chk_in are captured only at the first clock edge where mode_hi is high after being low. Bus changes while mode_hi stays high have no effect on the captured word.
- R4: The syndrome is the check word of the captured data XOR the captured check bits. With mode 10, chk_out shows the syndrome.
- R5: If the captured word has no error, the syndrome is zero, both flags are low, and data_out equals the captured data.
- R6: If exactly one data bit i is wrong, err_single is high and data_out is the corrected data. The syndrome equals column i.
- R7: If exactly one check bit j is wrong, err_single is high and data_out equals the captured data. The syndrome has only bit j set.
- R8: Any two-bit error in the 22-bit word sets err_double, and data_out equals the captured data unchanged.
- R9: A captured 22-bit word of all zeros or all ones sets err_double.
- R10: err_single and err_double are never high together.
- R11: After reset the captured word is a clean codeword of zero data, both flags are low, and data_out is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_hi | input | 1 | Upper mode select; its rising edge captures the buses |
| mode_lo | input | 1 | Lower mode select; when high, both outputs are released |
| data_in | input | 16 | Data bus input |
| chk_in | input | 6 | Check bus input |
| data_out | output | 16 | Corrected data |
| data_oe | output | 1 | Data bus drive enable |
| chk_out | output | 6 | Generated check word (mode 00) or syndrome (other modes) |
| chk_oe | output | 1 | Check bus drive enable |
| err_single | output | 1 | Single-bit error flag |
| err_double | output | 1 | Uncorrectable error flag |

## Verification
Two functions can meet in the same cycle.

The first is capture on the mode_hi rise. The bench changes data_in while mode_hi is still held high, one cycle after the edge. It then confirms that the driven data and flags still match the word present at the edge.

The second is a generate request against an old captured word. After a faulty word has been captured, the bench switches to mode 00. It checks that chk_out shows the freshly generated check word while the error flags still describe the old captured word.

// File: rtl/edac_sec_ded.sv
module edac_sec_ded (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_hi,
  input  logic        mode_lo,
  input  logic [15:0] data_in,
  input  logic [5:0]  chk_in,
  output logic [15:0] data_out,
  output logic        data_oe,
  output logic [5:0]  chk_out,
  output logic        chk_oe,
  output logic        err_single,
  output logic        err_double
);
  localparam int DW = 16;
  localparam int CW = 6;
  localparam logic [CW-1:0] INV_MASK = 6'b000011;

  function automatic logic [CW-1:0] col(input int i);
    case (i)
      0: col = 6'd13;   1: col = 6'd14;   2: col = 6'd19;   3: col = 6'd21;
      4: col = 6'd22;   5: col = 6'd25;   6: col = 6'd26;   7: col = 6'd28;
      8: col = 6'd35;   9: col = 6'd37;  10: col = 6'd38;  11: col = 6'd41;
      12: col = 6'd42; 13: col = 6'd44;  14: col = 6'd49;  default: col = 6'd50;
    endcase
  endfunction

  function automatic logic [CW-1:0] gen(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) c = c ^ col(i);
    return c ^ INV_MASK;
  endfunction

  logic [DW-1:0] data_q;
  logic [CW-1:0] chk_q;
  logic          hi_d;
  logic          hi_rise;
  logic [CW-1:0] syn;
  logic [DW-1:0] fix;
  logic          one_chk;

  assign hi_rise = mode_hi && !hi_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_d   <= 1'b0;
      data_q <= '0;
      chk_q  <= INV_MASK;
    end else begin
      hi_d <= mode_hi;
      if (hi_rise) begin
        data_q <= data_in;
        chk_q  <= chk_in;
      end
    end
  end

  assign syn = gen(data_q) ^ chk_q;

  always_comb begin
    for (int i = 0; i < DW; i++)
      fix[i] = (syn == col(i));
  end

  assign one_chk    = ($countones(syn) == 1);
  assign err_single = (|fix) || one_chk;
  assign err_double = (syn != '0) && !err_single;

  assign data_out = data_q ^ fix;
  assign data_oe  = mode_hi && !mode_lo;
  assign chk_oe   = !mode_lo;
  assign chk_out  = (!mode_hi && !mode_lo) ? gen(data_in) : syn;

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_single && err_double));
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && !hi_d) |=> (data_q == $past(data_in)) && (chk_q == $past(chk_in)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_d && mode_hi) |=> $stable(data_q) && $stable(chk_q));
  p_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> chk_oe);
  p_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (syn == '0) |-> (!err_single && !err_double && data_out == data_q));
  p_chkerr_nofix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    one_chk |-> (data_out == data_q));
  p_double_nofix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_double |-> (data_out == data_q));
  p_single_fix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(data_out ^ data_q) <= 1));
endmodule

// File: tb/edac_sec_ded_bench.sv
module edac_sec_ded_bench;
  logic clk = 0, rst_n = 0, mode_hi = 0, mode_lo = 1;
  logic [15:0] data_in = '0;
  logic [5:0]  chk_in = '0;
  logic [15:0] data_out;
  logic        data_oe, chk_oe, err_single, err_double;
  logic [5:0]  chk_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edac_sec_ded u_edac_sec_ded (.*);

  function automatic logic [5:0] mcol(input int i);
    logic [5:0] t [16] = '{6'd13,6'd14,6'd19,6'd21,6'd22,6'd25,6'd26,6'd28,
                           6'd35,6'd37,6'd38,6'd41,6'd42,6'd44,6'd49,6'd50};
    return t[i];
  endfunction

  function automatic logic [5:0] mgen(input logic [15:0] d);
    logic [5:0] c = 6'b000011;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 16; i++) begin
        logic [5:0] k;
        k = mcol(i);
        if (k[j]) c[j] = c[j] ^ d[i];
      end
    return c;
  endfunction

  function automatic logic [5:0] pos_syn(input int p);
    if (p < 16) return mcol(p);
    return 6'b1 << (p - 16);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(input logic [15:0] d, input logic [5:0] c);
    @(negedge clk); mode_hi = 0; mode_lo = 1; data_in = d; chk_in = c;
    @(negedge clk); mode_hi = 1; mode_lo = 1;
    @(negedge clk); mode_hi = 1; mode_lo = 0; data_in = ~d; chk_in = ~c;
    #1;
  endtask

  localparam logic [25:0] VEC [8] = '{
    {16'h1234, 5'd31, 5'd31},
    {16'hA5C3, 5'd0,  5'd31},
    {16'h0F0F, 5'd15, 5'd31},
    {16'h8001, 5'd16, 5'd31},
    {16'h7E7E, 5'd21, 5'd31},
    {16'hFFFF, 5'd3,  5'd9 },
    {16'h0000, 5'd18, 5'd20},
    {16'hBEEF, 5'd7,  5'd19}};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    mode_hi = 1; mode_lo = 0;
    #1;
    check("R11 data", data_out, 16'h0);
    check("R11 flags", {err_single, err_double}, 2'b00);
    check("R11 syndrome", chk_out, 6'h0);
    check("R2 oe mode10", {data_oe, chk_oe}, 2'b11);

    foreach (VEC[k]) begin
      logic [15:0] d;
      logic [21:0] w;
      int a, b, nflip;
      logic [5:0] esyn;
      d = VEC[k][25:10]; a = VEC[k][9:5]; b = VEC[k][4:0];
      w = {mgen(d), d};
      nflip = 0; esyn = 0;
      if (a != 31) begin w[a] = ~w[a]; nflip++; esyn ^= pos_syn(a); end
      if (b != 31) begin w[b] = ~w[b]; nflip++; esyn ^= pos_syn(b); end
      read_word(w[15:0], w[21:16]);
      check("R4 syndrome", chk_out, esyn);
      if (nflip == 0) begin
        check("R5 flags", {err_single, err_double}, 2'b00);
        check("R5 data", data_out, d);
      end else if (nflip == 1 && a < 16) begin
        check("R6 flags", {err_single, err_double}, 2'b10);
        check("R6 corrected", data_out, d);
      end else if (nflip == 1) begin
        check("R7 flags", {err_single, err_double}, 2'b10);
        check("R7 data", data_out, w[15:0]);
      end else begin
        check("R8 flags", {err_single, err_double}, 2'b01);
        check("R8 data", data_out, w[15:0]);
      end
      check("R10 excl", err_single & err_double, 1'b0);
    end

    read_word(16'h0000, 6'h00);
    check("R9 zeros", {err_single, err_double}, 2'b01);
    read_word(16'hFFFF, 6'h3F);
    check("R9 ones", {err_single, err_double}, 2'b01);

    @(negedge clk); mode_hi = 0; mode_lo = 0; data_in = 16'hC0DE; #1;
    check("R1 gen", chk_out, mgen(16'hC0DE));
    check("R2 oe mode00", {data_oe, chk_oe}, 2'b01);
    check("R1 flags keep old word", {err_single, err_double}, 2'b01);
    data_in = 16'hFFFF; #1;
    check("R1 gen ones", chk_out, 6'b000011);
    @(negedge clk); mode_lo = 1; #1;
    check("R2 oe mode01", {data_oe, chk_oe}, 2'b00);

    @(negedge clk); mode_hi = 0; mode_lo = 1; data_in = 16'h5A5A; chk_in = mgen(16'h5A5A);
    @(negedge clk); mode_hi = 1;
    #1; check("R2 oe mode11", {data_oe, chk_oe}, 2'b00);
    @(negedge clk); data_in = 16'h0001; chk_in = 6'h00;
    @(negedge clk); mode_lo = 0; #1;
    check("R3 held data", data_out, 16'h5A5A);
    check("R3 held flags", {err_single, err_double}, 2'b00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule